// File: doc/BRIEF.md
# Debug Address Trigger Unit

This block watches a simple 32-bit processor for two kinds of debug events. It compares the address of each issued instruction against a set of breakpoint slots. It compares every data-memory read or write against a set of watchpoint slots. Each watchpoint slot carries a two-bit mode that selects which kinds of access can fire it. A watchpoint match stops the access before it takes effect: the block asserts a combinational suppress line to the memory stage in the same cycle as the match. One cycle later, a one-cycle exception request goes to the core.

Software programs the slots through a small register port: write enable, word select and 32-bit data. A slot becomes valid when its address is written, and stops being valid when a remove word names it. A sticky status register records which slots caused each reported event. Bits in the status register are cleared by writing 1 to them.

A three-state sequencer orders the events. The states are ST_IDLE (no request), ST_WATCH_REQ (the watchpoint request is presented) and ST_BREAK_REQ (the breakpoint request is presented). The state is re-chosen every cycle from the current matches. Any watchpoint match moves the sequencer to ST_WATCH_REQ. Otherwise, any breakpoint match moves it to ST_BREAK_REQ. Otherwise it goes to ST_IDLE. These moves apply from every state, so back-to-back events give back-to-back one-cycle requests.

Top module: `dbg_trigger_unit`

## Requirements
- R1: While reset is asserted and after it is released, no slot is valid and every watch mode is off. `bp_exc`, `wp_exc` and `dmem_suppress` are low and `hit_status` is zero. A PC or data address of zero raises nothing.
- R2: The word select `cfg_addr` decodes as follows:
  - 0..3 writes breakpoint slot k's address and makes the slot valid.
  - 4..7 writes watchpoint slot k−4's address and makes the slot valid.
  - 8..11 writes watchpoint slot k−8's mode from `cfg_wdata[1:0]`.
  - 12 removes the breakpoint slots whose bits are set in `cfg_wdata[3:0]`.
  - 13 removes the watchpoint slots whose bits are set in `cfg_wdata[3:0]`.
  - 14 clears status bits.

  A write takes effect at the clock edge that samples it. Comparisons in that same cycle still use the old contents.
- R3: When `pc_vld` is high and `pc` equals the address of a valid breakpoint slot, `bp_exc` is high for the one cycle after the match, and the slot's status bit `hit_status[k]` is set.
- R4: The watch mode is encoded as 00 off, 01 read, 10 write and 11 read-or-write. A read fires a slot only in modes 01 and 11. A write fires a slot only in modes 10 and 11.
- R5: A valid watchpoint slot in mode 00 never matches, for either kind of access.
- R6: On a watchpoint match, `dmem_suppress` is high combinationally in the same cycle, and `wp_exc` is high for the following cycle. Without a match, `dmem_suppress` is low.
- R7: Only exact 32-bit address equality counts as a match, for both breakpoints and watchpoints.
- R8: In a cycle with a watchpoint match, breakpoints are not evaluated. Only `wp_exc` follows, and no breakpoint status bit is set for that cycle.
- R9: When several watchpoint slots match at once, a single `wp_exc` pulse follows. Every matching slot k sets `hit_status[4+k]`.
- R10: Writing 1 to a bit of `hit_status` (select 14) clears it. If a new hit sets the same bit in the same cycle, the set wins.
- R11: Removing a slot that is not valid changes nothing. Removing a valid slot stops it from matching, and the other slots keep matching.
- R12: A status bit, once set, holds its value until it is cleared by a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write enable |
| cfg_addr | input | 4 | Register word select |
| cfg_wdata | input | 32 | Register write data |
| pc_vld | input | 1 | An instruction is issued at `pc` this cycle |
| pc | input | 32 | Address of the issued instruction |
| dmem_rd | input | 1 | Data read strobe |
| dmem_wr | input | 1 | Data write strobe |
| dmem_addr | input | 32 | Data access byte address |
| dmem_suppress | output | 1 | Stop the current data access (watchpoint match) |
| bp_exc | output | 1 | Breakpoint exception request, one cycle |
| wp_exc | output | 1 | Watchpoint exception request, one cycle |
| hit_status | output | 8 | Sticky hit bits: [3:0] breakpoint slots, [7:4] watchpoint slots |

## Verification
A wrong sequencer state shows up on `bp_exc` or `wp_exc` exactly one cycle after the access or fetch that caused it. Examples are a request of the wrong kind, a request that comes twice, or a breakpoint request during a watch match. A stale valid bit or a stale mode shows up in the same cycle as a wrong `dmem_suppress`, because that line is combinational. A corrupted status register shows up on `hit_status` at the edge after the event, and it stays visible until software clears it. That makes the sticky and write-1-to-clear rules observable across idle cycles.

// File: rtl/dbg_trig_pkg.sv
package dbg_trig_pkg;

    typedef enum logic [1:0] {
        WM_OFF   = 2'b00,
        WM_READ  = 2'b01,
        WM_WRITE = 2'b10,
        WM_BOTH  = 2'b11
    } wmode_e;

    typedef enum logic [1:0] {
        ST_IDLE      = 2'b00,
        ST_WATCH_REQ = 2'b01,
        ST_BREAK_REQ = 2'b10
    } seq_state_e;

endpackage

// File: rtl/dbg_slot_regs.sv
module dbg_slot_regs
    import dbg_trig_pkg::*;
#(
    parameter int NBP = 4,
    parameter int NWP = 4,
    parameter int AW  = 32,
    parameter int CAW = 4,
    parameter int DW  = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cfg_we,
    input  logic [CAW-1:0]           cfg_addr,
    input  logic [DW-1:0]            cfg_wdata,
    output logic [NBP-1:0][AW-1:0]   bp_addr,
    output logic [NBP-1:0]           bp_vld,
    output logic [NWP-1:0][AW-1:0]   wp_addr,
    output logic [NWP-1:0]           wp_vld,
    output logic [NWP-1:0][1:0]      wp_mode,
    output logic [NBP+NWP-1:0]       stat_clr
);
    localparam int SEL_WP0   = NBP;
    localparam int SEL_MODE0 = NBP + NWP;
    localparam int SEL_RMBP  = NBP + 2 * NWP;
    localparam int SEL_RMWP  = SEL_RMBP + 1;
    localparam int SEL_STAT  = SEL_RMBP + 2;

    logic rm_bp_wr;
    logic rm_wp_wr;

    assign rm_bp_wr = cfg_we && (cfg_addr == CAW'(SEL_RMBP));
    assign rm_wp_wr = cfg_we && (cfg_addr == CAW'(SEL_RMWP));
    assign stat_clr = (cfg_we && (cfg_addr == CAW'(SEL_STAT)))
                    ? cfg_wdata[NBP+NWP-1:0] : '0;

    for (genvar i = 0; i < NBP; i++) begin : g_bp
        logic prog;
        assign prog = cfg_we && (cfg_addr == CAW'(i));
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                bp_addr[i] <= '0;
                bp_vld[i]  <= 1'b0;
            end else if (prog) begin
                bp_addr[i] <= cfg_wdata[AW-1:0];
                bp_vld[i]  <= 1'b1;
            end else if (rm_bp_wr && cfg_wdata[i]) begin
                bp_vld[i]  <= 1'b0;
            end
        end
    end

    for (genvar j = 0; j < NWP; j++) begin : g_wp
        logic prog;
        logic mset;
        assign prog = cfg_we && (cfg_addr == CAW'(SEL_WP0 + j));
        assign mset = cfg_we && (cfg_addr == CAW'(SEL_MODE0 + j));
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                wp_addr[j] <= '0;
                wp_vld[j]  <= 1'b0;
            end else if (prog) begin
                wp_addr[j] <= cfg_wdata[AW-1:0];
                wp_vld[j]  <= 1'b1;
            end else if (rm_wp_wr && cfg_wdata[j]) begin
                wp_vld[j]  <= 1'b0;
            end
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)    wp_mode[j] <= WM_OFF;
            else if (mset) wp_mode[j] <= cfg_wdata[1:0];
        end
    end

endmodule

// File: rtl/dbg_addr_match.sv
module dbg_addr_match
    import dbg_trig_pkg::*;
#(
    parameter int NBP = 4,
    parameter int NWP = 4,
    parameter int AW  = 32
) (
    input  logic                   pc_vld,
    input  logic [AW-1:0]          pc,
    input  logic                   dmem_rd,
    input  logic                   dmem_wr,
    input  logic [AW-1:0]          dmem_addr,
    input  logic [NBP-1:0][AW-1:0] bp_addr,
    input  logic [NBP-1:0]         bp_vld,
    input  logic [NWP-1:0][AW-1:0] wp_addr,
    input  logic [NWP-1:0]         wp_vld,
    input  logic [NWP-1:0][1:0]    wp_mode,
    output logic [NBP-1:0]         bp_hit,
    output logic [NWP-1:0]         wp_hit
);
    for (genvar i = 0; i < NBP; i++) begin : g_bpc
        assign bp_hit[i] = pc_vld && bp_vld[i] && (bp_addr[i] == pc);
    end

    for (genvar j = 0; j < NWP; j++) begin : g_wpc
        logic rd_arm;
        logic wr_arm;
        assign rd_arm = (wp_mode[j] == WM_READ)  || (wp_mode[j] == WM_BOTH);
        assign wr_arm = (wp_mode[j] == WM_WRITE) || (wp_mode[j] == WM_BOTH);
        assign wp_hit[j] = wp_vld[j] && (wp_addr[j] == dmem_addr)
                         && ((dmem_rd && rd_arm) || (dmem_wr && wr_arm));
    end

endmodule

// File: rtl/dbg_event_seq.sv
module dbg_event_seq
    import dbg_trig_pkg::*;
#(
    parameter int NBP = 4,
    parameter int NWP = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NBP-1:0]         bp_hit,
    input  logic [NWP-1:0]         wp_hit,
    input  logic [NBP+NWP-1:0]     stat_clr,
    output logic                   bp_exc,
    output logic                   wp_exc,
    output logic [NBP+NWP-1:0]     hit_status
);
    seq_state_e state_q;
    seq_state_e state_d;
    logic       wp_any;
    logic       bp_any;
    logic [NBP+NWP-1:0] stat_set;

    assign wp_any = |wp_hit;
    assign bp_any = |bp_hit;

    // Watch matches win; breakpoints are not evaluated in such a cycle.
    always_comb begin
        state_d  = ST_IDLE;
        stat_set = '0;
        if (wp_any) begin
            state_d  = ST_WATCH_REQ;
            stat_set = {wp_hit, {NBP{1'b0}}};
        end else if (bp_any) begin
            state_d  = ST_BREAK_REQ;
            stat_set = {{NWP{1'b0}}, bp_hit};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        bp_exc = 1'b0;
        wp_exc = 1'b0;
        unique case (state_q)
            ST_IDLE:      ;
            ST_WATCH_REQ: wp_exc = 1'b1;
            ST_BREAK_REQ: bp_exc = 1'b1;
            default:      ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hit_status <= '0;
        else        hit_status <= (hit_status & ~stat_clr) | stat_set;
    end

endmodule

// File: rtl/dbg_trigger_unit.sv
module dbg_trigger_unit
    import dbg_trig_pkg::*;
#(
    parameter int NBP = 4,
    parameter int NWP = 4,
    parameter int AW  = 32,
    parameter int DW  = 32,
    parameter int CAW = $clog2(NBP + 2 * NWP + 3)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [CAW-1:0]     cfg_addr,
    input  logic [DW-1:0]      cfg_wdata,
    input  logic               pc_vld,
    input  logic [AW-1:0]      pc,
    input  logic               dmem_rd,
    input  logic               dmem_wr,
    input  logic [AW-1:0]      dmem_addr,
    output logic               dmem_suppress,
    output logic               bp_exc,
    output logic               wp_exc,
    output logic [NBP+NWP-1:0] hit_status
);
    logic [NBP-1:0][AW-1:0] bp_addr;
    logic [NBP-1:0]         bp_vld;
    logic [NWP-1:0][AW-1:0] wp_addr;
    logic [NWP-1:0]         wp_vld;
    logic [NWP-1:0][1:0]    wp_mode;
    logic [NBP+NWP-1:0]     stat_clr;
    logic [NBP-1:0]         bp_hit;
    logic [NWP-1:0]         wp_hit;

    dbg_slot_regs #(.NBP(NBP), .NWP(NWP), .AW(AW), .CAW(CAW), .DW(DW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .bp_addr   (bp_addr),
        .bp_vld    (bp_vld),
        .wp_addr   (wp_addr),
        .wp_vld    (wp_vld),
        .wp_mode   (wp_mode),
        .stat_clr  (stat_clr)
    );

    dbg_addr_match #(.NBP(NBP), .NWP(NWP), .AW(AW)) u_match (
        .pc_vld    (pc_vld),
        .pc        (pc),
        .dmem_rd   (dmem_rd),
        .dmem_wr   (dmem_wr),
        .dmem_addr (dmem_addr),
        .bp_addr   (bp_addr),
        .bp_vld    (bp_vld),
        .wp_addr   (wp_addr),
        .wp_vld    (wp_vld),
        .wp_mode   (wp_mode),
        .bp_hit    (bp_hit),
        .wp_hit    (wp_hit)
    );

    dbg_event_seq #(.NBP(NBP), .NWP(NWP)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .bp_hit     (bp_hit),
        .wp_hit     (wp_hit),
        .stat_clr   (stat_clr),
        .bp_exc     (bp_exc),
        .wp_exc     (wp_exc),
        .hit_status (hit_status)
    );

    assign dmem_suppress = |wp_hit;

endmodule

// File: rtl/dbg_trigger_chk.sv
module dbg_trigger_chk #(
    parameter int NBP = 4,
    parameter int NWP = 4,
    parameter int DW  = 32,
    parameter int CAW = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               cfg_we,
    input logic [CAW-1:0]     cfg_addr,
    input logic [DW-1:0]      cfg_wdata,
    input logic               dmem_rd,
    input logic               dmem_wr,
    input logic               dmem_suppress,
    input logic               bp_exc,
    input logic               wp_exc,
    input logic [NBP+NWP-1:0] hit_status
);
    localparam int CLR_SEL = NBP + 2 * NWP + 2;
    logic [NBP+NWP-1:0] clr_mask;
    assign clr_mask = (cfg_we && cfg_addr == CAW'(CLR_SEL)) ? cfg_wdata[NBP+NWP-1:0] : '0;

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> (!bp_exc && !wp_exc && hit_status == '0)); // R1
    AST_SUPPRESS_THEN_WP: assert property (@(posedge clk) disable iff (!rst_n)
        dmem_suppress |=> wp_exc); // R6
    AST_NO_WP_UNSUPPRESSED: assert property (@(posedge clk) disable iff (!rst_n)
        !dmem_suppress |=> !wp_exc); // R6
    AST_ONE_REQUEST: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({bp_exc, wp_exc})); // R8
    AST_IDLE_BUS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !(dmem_rd || dmem_wr) |-> !dmem_suppress); // R4
    AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(hit_status) & ~$past(clr_mask) & ~hit_status) == '0)); // R12
    AST_WP_RECORDED: assert property (@(posedge clk) disable iff (!rst_n)
        wp_exc |-> (hit_status[NBP+NWP-1:NBP] != '0)); // R9
    AST_BP_RECORDED: assert property (@(posedge clk) disable iff (!rst_n)
        bp_exc |-> (hit_status[NBP-1:0] != '0)); // R3
endmodule

bind dbg_trigger_unit dbg_trigger_chk #(.NBP(NBP), .NWP(NWP), .DW(DW), .CAW(CAW)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_we        (cfg_we),
    .cfg_addr      (cfg_addr),
    .cfg_wdata     (cfg_wdata),
    .dmem_rd       (dmem_rd),
    .dmem_wr       (dmem_wr),
    .dmem_suppress (dmem_suppress),
    .bp_exc        (bp_exc),
    .wp_exc        (wp_exc),
    .hit_status    (hit_status)
);

// File: tb/dbg_trigger_unit_tb.sv
module dbg_trigger_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic        pc_vld = 1'b0;
    logic [31:0] pc = '0;
    logic        dmem_rd = 1'b0;
    logic        dmem_wr = 1'b0;
    logic [31:0] dmem_addr = '0;
    logic        dmem_suppress, bp_exc, wp_exc;
    logic [7:0]  hit_status;
    int n_run = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    dbg_trigger_unit u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .pc_vld(pc_vld), .pc(pc), .dmem_rd(dmem_rd),
        .dmem_wr(dmem_wr), .dmem_addr(dmem_addr), .dmem_suppress(dmem_suppress),
        .bp_exc(bp_exc), .wp_exc(wp_exc), .hit_status(hit_status)
    );

    // {pc_vld, pc, rd, wr, daddr, exp_suppress, exp_bp, exp_wp}
    localparam int NV = 15;
    localparam logic [69:0] VEC [NV] = '{
        {1'b1, 32'h0000_0100, 1'b0, 1'b0, 32'h0000_0000, 3'b010}, // R3 bp0
        {1'b1, 32'h0000_0104, 1'b0, 1'b0, 32'h0000_0000, 3'b000}, // R7
        {1'b0, 32'h0000_0100, 1'b0, 1'b0, 32'h0000_0000, 3'b000}, // R3 no issue
        {1'b0, 32'h0000_0000, 1'b1, 1'b0, 32'h0000_1000, 3'b101}, // R4 read mode
        {1'b0, 32'h0000_0000, 1'b0, 1'b1, 32'h0000_1000, 3'b000}, // R4
        {1'b0, 32'h0000_0000, 1'b0, 1'b1, 32'h0000_2000, 3'b101}, // R4 write mode
        {1'b0, 32'h0000_0000, 1'b1, 1'b0, 32'h0000_2000, 3'b000}, // R4
        {1'b0, 32'h0000_0000, 1'b1, 1'b0, 32'h0000_3000, 3'b101}, // R4 both
        {1'b0, 32'h0000_0000, 1'b0, 1'b1, 32'h0000_3000, 3'b101}, // R4 both
        {1'b0, 32'h0000_0000, 1'b1, 1'b0, 32'h0000_4000, 3'b000}, // R5
        {1'b0, 32'h0000_0000, 1'b0, 1'b1, 32'h0000_4000, 3'b000}, // R5
        {1'b0, 32'h0000_0000, 1'b1, 1'b0, 32'h0000_1001, 3'b000}, // R7
        {1'b1, 32'h0000_0201, 1'b0, 1'b0, 32'h0000_0000, 3'b000}, // R7
        {1'b1, 32'h0000_0100, 1'b1, 1'b0, 32'h0000_1000, 3'b101}, // R8
        {1'b1, 32'h0000_0200, 1'b0, 1'b1, 32'h0000_1000, 3'b010}  // R3 bp1
    };

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic cfg_write(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(posedge clk); #1;
        cfg_we = 1'b0;
    endtask

    task automatic idle_bus();
        pc_vld = 1'b0; dmem_rd = 1'b0; dmem_wr = 1'b0;
    endtask

    initial begin
        #1_000_000;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R1 bp_exc in reset", {31'd0, bp_exc}, 32'd0);
        check("R1 status in reset", {24'd0, hit_status}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        // all-zero addresses must hit nothing after reset
        pc_vld = 1'b1; pc = '0; dmem_rd = 1'b1; dmem_wr = 1'b1; dmem_addr = '0;
        #1 check("R1 suppress", {31'd0, dmem_suppress}, 32'd0);
        @(posedge clk); #1;
        check("R1 requests", {30'd0, bp_exc, wp_exc}, 32'd0);
        idle_bus();

        cfg_write(4'd0, 32'h100);
        cfg_write(4'd1, 32'h200);
        cfg_write(4'd4, 32'h1000); cfg_write(4'd8,  32'd1);
        cfg_write(4'd5, 32'h2000); cfg_write(4'd9,  32'd2);
        cfg_write(4'd6, 32'h3000); cfg_write(4'd10, 32'd3);
        cfg_write(4'd7, 32'h4000); cfg_write(4'd11, 32'd0);

        for (int v = 0; v < NV; v++) begin
            @(negedge clk);
            {pc_vld, pc, dmem_rd, dmem_wr, dmem_addr} = VEC[v][69:3];
            #1 check($sformatf("R6 vec%0d suppress", v), {31'd0, dmem_suppress}, {31'd0, VEC[v][2]});
            @(posedge clk); #1;
            check($sformatf("R3/R4/R8 vec%0d requests", v), {30'd0, bp_exc, wp_exc}, {30'd0, VEC[v][1:0]});
        end
        @(negedge clk); idle_bus();
        @(posedge clk); #1;
        check("R8 table status", {24'd0, hit_status}, 32'h73);
        cfg_write(4'd14, 32'hFF);
        check("R10 clear all", {24'd0, hit_status}, 32'd0);

        // R2: write and compare in the same cycle use old contents
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 4'd3; cfg_wdata = 32'h500; pc_vld = 1'b1; pc = 32'h500;
        @(posedge clk); #1;
        cfg_we = 1'b0;
        check("R2 old slot used", {31'd0, bp_exc}, 32'd0);
        @(posedge clk); #1;
        check("R2 new slot used", {31'd0, bp_exc}, 32'd1);
        check("R3 status bit3", {24'd0, hit_status}, 32'h08);
        @(negedge clk); idle_bus();
        cfg_write(4'd14, 32'h08);

        // R9: two watch slots on one address
        cfg_write(4'd5, 32'h3000);
        @(negedge clk);
        dmem_wr = 1'b1; dmem_addr = 32'h3000;
        #1 check("R9 suppress", {31'd0, dmem_suppress}, 32'd1);
        @(posedge clk); #1;
        check("R9 single request", {30'd0, bp_exc, wp_exc}, 32'd1);
        check("R9 both slots", {24'd0, hit_status}, 32'h60);
        @(negedge clk); idle_bus();

        // R10: set wins over clear in the same cycle
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 4'd14; cfg_wdata = 32'hFF; pc_vld = 1'b1; pc = 32'h100;
        @(posedge clk); #1;
        cfg_we = 1'b0;
        check("R10 set wins", {24'd0, hit_status}, 32'h01);
        @(negedge clk); idle_bus();
        repeat (3) @(posedge clk);
        #1 check("R12 sticky", {24'd0, hit_status}, 32'h01);
        cfg_write(4'd14, 32'h01);
        check("R10 clear one", {24'd0, hit_status}, 32'd0);

        // R11: remove an unprogrammed slot, then a programmed one
        cfg_write(4'd12, 32'h4);
        @(negedge clk); pc_vld = 1'b1; pc = 32'h100;
        @(posedge clk); #1;
        check("R11 unprogrammed remove", {31'd0, bp_exc}, 32'd1);
        @(negedge clk); idle_bus();
        cfg_write(4'd12, 32'h1);
        cfg_write(4'd14, 32'hFF);
        @(negedge clk); pc_vld = 1'b1; pc = 32'h100;
        @(posedge clk); #1;
        check("R11 removed slot", {31'd0, bp_exc}, 32'd0);
        check("R11 removed status", {24'd0, hit_status}, 32'd0);
        @(negedge clk); pc = 32'h200;
        @(posedge clk); #1;
        check("R11 other slot", {31'd0, bp_exc}, 32'd1);
        @(negedge clk); idle_bus();

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule